// File: doc/BRIEF.md
# Dual-CPU Interrupt Level Controller

This block collects interrupt triggers from several system sources and turns them into one encoded priority level for each of two processors. The sources arrive as one-hot bits on a shared trigger bus. A reset request reaches both processors with no gating. The frame-blank, line-blank and PWM timer sources are latched per processor, and only where that processor's enable mask allows them. A command interrupt is not latched at all. It follows a shared two-bit command register, ANDed with each processor's mask.

Each processor sees a registered level equal to twice the index of its highest pending source. During an acknowledge cycle the block returns a vector. It arbitrates between the external level and one internal peripheral request, which is loaded per processor through a single level-and-vector input. When the internal request wins, it is retired automatically and the external level at that moment is recorded for the processor.

Top module: `dual_irq_level_ctrl`

## Requirements
- R1: After reset, both level outputs and both recorded-level outputs are 0.
- R2: Trigger bit 6 (frame blank), bit 5 (line blank) and bit 3 (PWM timer) are latched into a processor's pending set only if that processor's mask bit 3, 2 or 0 respectively is 1. The mask value in force before the trigger's clock edge is the one used.
- R3: Trigger bit 7 (reset request) is latched into a set shared by both processors regardless of either mask, so both levels become 14.
- R4: Each level output equals twice the index of the highest set bit of (shared set OR that processor's set OR its command bit at position 4), or 0 if none is set. It changes on the clock edge that registers the trigger, mask write or command write, and not before.
- R5: The command bit for processor k is present while its mask bit 1 and command-register bit k are both 1, and is gone one cycle after either is written to 0. Trigger bits 4, 2, 1 and 0 latch nothing.
- R6: A latched source stays pending after its mask bit is cleared, and later triggers are then blocked.
- R7: If the selected processor's level is greater than its internal request level, ack_vec_o = 64 + level/2 in the same cycle as ack_i, and the internal request and recorded level are left unchanged.
- R8: Otherwise ack_vec_o is the stored internal vector. The internal request level drops to 0, and the recorded level takes the current external level on the next edge.
- R9: pint_set_i bit k loads pint_lvl_i and pint_vec_i as processor k's internal request, and touches no other processor.
- R10: clr_i zeroes all pending sets, masks, the command register, the internal requests and the recorded levels on the next edge, taking precedence over any trigger in the same cycle.
- R11: An acknowledge acts only on the processor named by ack_sel_i (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all state |
| trig_i | input | 8 | One-hot source trigger pulses |
| mask_we_i | input | 2 | Per-processor mask write enable |
| mask_wdata_i | input | 4 | Mask write data |
| cmd_we_i | input | 1 | Command register write enable |
| cmd_wdata_i | input | 2 | Command register data, bit k for processor k |
| pint_set_i | input | 2 | Per-processor internal request load |
| pint_lvl_i | input | 4 | Internal request level |
| pint_vec_i | input | 8 | Internal request vector |
| ack_i | input | 1 | Acknowledge strobe |
| ack_sel_i | input | 1 | Processor being acknowledged |
| ack_vec_o | output | 8 | Vector returned during acknowledge |
| lvl_o | output | 8 | Encoded levels, processor k at bits 4k+3..4k |
| rec_o | output | 8 | Recorded levels, processor k at bits 4k+3..4k |

## Verification
Each single trigger bit is driven against all sixteen mask values for each processor in turn. This separates masked from unmasked latching, unmasked reset-request routing and the bits that must be ignored. It also confirms that one processor's mask never gates the other. Every combination of command value and mask bit 1 shows that the command contribution is a live AND rather than a latch. Sticky pending after a mask clear is tried separately. The acknowledge sweep pits every internal level 0 to 15 against no external level and against levels 6, 10 and 14. This exposes the strict greater-than boundary, the auto-retire and recording, and the isolation between the two processors.

// File: rtl/dilc_pkg.sv
package dilc_pkg;
    // Default geometry of the source bus and vectors
    localparam int unsigned SRC_W      = 8;
    localparam int unsigned MASK_W     = 4;
    localparam int unsigned MASK_SHIFT = 3;
    localparam int unsigned RST_BIT    = 7;
    localparam int unsigned CMD_BIT    = 4;
    localparam int unsigned VEC_W      = 8;
    localparam int unsigned VEC_BASE   = 64;
    localparam int unsigned NCPU       = 2;
endpackage

// File: rtl/dilc_prio_enc.sv
module dilc_prio_enc #(
    parameter int unsigned W     = 8,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o
);
    // highest set index wins; 0 when nothing is set
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dilc_cpu_lane.sv
module dilc_cpu_lane #(
    parameter int unsigned SRC_W      = 8,
    parameter int unsigned MASK_W     = 4,
    parameter int unsigned MASK_SHIFT = 3,
    parameter int unsigned CMD_BIT    = 4,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 64,
    localparam int unsigned IDX_W     = $clog2(SRC_W),
    localparam int unsigned LVL_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [SRC_W-1:0]  trig_i,
    input  logic [SRC_W-1:0]  shared_d_i,
    input  logic              cmd_bit_d_i,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] mask_wdata_i,
    input  logic              pint_set_i,
    input  logic [LVL_W-1:0]  pint_lvl_i,
    input  logic [VEC_W-1:0]  pint_vec_i,
    input  logic              ack_i,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [LVL_W-1:0]  rec_o,
    output logic [VEC_W-1:0]  vec_o
);
    localparam int unsigned CMD_MBIT = CMD_BIT - MASK_SHIFT;

    typedef struct packed {
        logic [SRC_W-1:0]  pend;
        logic [MASK_W-1:0] mask;
        logic [LVL_W-1:0]  lvl;
        logic [LVL_W-1:0]  ilvl;
        logic [VEC_W-1:0]  ivec;
        logic [LVL_W-1:0]  rec;
    } lane_st_t;

    lane_st_t st_q, st_d;

    logic [SRC_W-1:0]  gate_w;
    logic [SRC_W-1:0]  pend_nx_w;
    logic [MASK_W-1:0] mask_nx_w;
    logic [SRC_W-1:0]  union_w;
    logic [IDX_W-1:0]  top_idx_w;
    logic              ext_wins_w;

    // next pending set and mask, kept apart so the encoder sees them
    always_comb begin
        gate_w          = SRC_W'(st_q.mask) << MASK_SHIFT;
        gate_w[CMD_BIT] = 1'b0;
        pend_nx_w       = clr_i ? '0 : (st_q.pend | (trig_i & gate_w));
        mask_nx_w       = clr_i ? '0 : (mask_we_i ? mask_wdata_i : st_q.mask);
        union_w         = shared_d_i | pend_nx_w;
        union_w[CMD_BIT] = union_w[CMD_BIT] | (mask_nx_w[CMD_MBIT] & cmd_bit_d_i);
    end

    dilc_prio_enc #(.W(SRC_W)) enc_i (
        .vec_i (union_w),
        .idx_o (top_idx_w)
    );

    assign ext_wins_w = st_q.lvl > st_q.ilvl;

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nx_w;
        st_d.mask = mask_nx_w;
        st_d.lvl  = {top_idx_w, 1'b0};
        if (ack_i && !ext_wins_w) begin
            st_d.ilvl = '0;
            st_d.rec  = st_q.lvl;
        end
        if (pint_set_i) begin
            st_d.ilvl = pint_lvl_i;
            st_d.ivec = pint_vec_i;
        end
        if (clr_i) begin
            st_d.ilvl = '0;
            st_d.ivec = '0;
            st_d.rec  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;
    assign rec_o = st_q.rec;
    assign vec_o = ext_wins_w ? (VEC_W'(VEC_BASE) + VEC_W'(st_q.lvl >> 1)) : st_q.ivec;
endmodule

// File: rtl/dual_irq_level_ctrl.sv
module dual_irq_level_ctrl #(
    parameter int unsigned SRC_W      = dilc_pkg::SRC_W,
    parameter int unsigned MASK_W     = dilc_pkg::MASK_W,
    parameter int unsigned MASK_SHIFT = dilc_pkg::MASK_SHIFT,
    parameter int unsigned RST_BIT    = dilc_pkg::RST_BIT,
    parameter int unsigned CMD_BIT    = dilc_pkg::CMD_BIT,
    parameter int unsigned VEC_W      = dilc_pkg::VEC_W,
    parameter int unsigned VEC_BASE   = dilc_pkg::VEC_BASE,
    parameter int unsigned NCPU       = dilc_pkg::NCPU,
    localparam int unsigned LVL_W     = $clog2(SRC_W) + 1,
    localparam int unsigned SEL_W     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic [SRC_W-1:0]      trig_i,
    input  logic [NCPU-1:0]       mask_we_i,
    input  logic [MASK_W-1:0]     mask_wdata_i,
    input  logic                  cmd_we_i,
    input  logic [NCPU-1:0]       cmd_wdata_i,
    input  logic [NCPU-1:0]       pint_set_i,
    input  logic [LVL_W-1:0]      pint_lvl_i,
    input  logic [VEC_W-1:0]      pint_vec_i,
    input  logic                  ack_i,
    input  logic [SEL_W-1:0]      ack_sel_i,
    output logic [VEC_W-1:0]      ack_vec_o,
    output logic [NCPU*LVL_W-1:0] lvl_o,
    output logic [NCPU*LVL_W-1:0] rec_o
);
    localparam logic [SRC_W-1:0] RST_ONEHOT = SRC_W'(1) << RST_BIT;

    typedef struct packed {
        logic [SRC_W-1:0] shared;
        logic [NCPU-1:0]  cmd;
    } top_st_t;

    top_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.shared = st_q.shared | (trig_i & RST_ONEHOT);
        if (cmd_we_i) st_d.cmd = cmd_wdata_i;
        if (clr_i)    st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [VEC_W-1:0] lane_vec [NCPU];

    for (genvar k = 0; k < int'(NCPU); k++) begin : g_lane
        dilc_cpu_lane #(
            .SRC_W      (SRC_W),
            .MASK_W     (MASK_W),
            .MASK_SHIFT (MASK_SHIFT),
            .CMD_BIT    (CMD_BIT),
            .VEC_W      (VEC_W),
            .VEC_BASE   (VEC_BASE)
        ) lane_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr_i        (clr_i),
            .trig_i       (trig_i),
            .shared_d_i   (st_d.shared),
            .cmd_bit_d_i  (st_d.cmd[k]),
            .mask_we_i    (mask_we_i[k]),
            .mask_wdata_i (mask_wdata_i),
            .pint_set_i   (pint_set_i[k]),
            .pint_lvl_i   (pint_lvl_i),
            .pint_vec_i   (pint_vec_i),
            .ack_i        (ack_i && (ack_sel_i == SEL_W'(k))),
            .lvl_o        (lvl_o[k*LVL_W +: LVL_W]),
            .rec_o        (rec_o[k*LVL_W +: LVL_W]),
            .vec_o        (lane_vec[k])
        );
    end

    assign ack_vec_o = lane_vec[ack_sel_i];
endmodule

// File: rtl/dilc_checker.sv
module dilc_checker #(
    parameter int unsigned SRC_W    = 8,
    parameter int unsigned RST_BIT  = 7,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned NCPU     = 2,
    parameter int unsigned LVL_W    = 4,
    parameter int unsigned SEL_W    = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr_i,
    input logic [SRC_W-1:0]      trig_i,
    input logic [NCPU-1:0]       mask_we_i,
    input logic                  cmd_we_i,
    input logic                  ack_i,
    input logic [SEL_W-1:0]      ack_sel_i,
    input logic [VEC_W-1:0]      ack_vec_o,
    input logic [NCPU*LVL_W-1:0] lvl_o,
    input logic [NCPU*LVL_W-1:0] rec_o
);
    localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(2 * RST_BIT);

    a_r3_rst_both: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i[RST_BIT] && !clr_i) |=>
            (lvl_o[LVL_W-1:0] == RST_LVL) && (lvl_o[2*LVL_W-1:LVL_W] == RST_LVL));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lvl_o == '0) && (rec_o == '0));

    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == '0 && mask_we_i == '0 && !cmd_we_i && !clr_i) |=> $stable(lvl_o));

    a_r8_record: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_sel_i == '0 && ack_vec_o < VEC_W'(VEC_BASE) && !clr_i) |=>
            rec_o[LVL_W-1:0] == $past(lvl_o[LVL_W-1:0]));

    a_r8_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !clr_i) |=> $stable(rec_o));

    a_r11_other_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_sel_i == '0 && !clr_i) |=> $stable(rec_o[2*LVL_W-1:LVL_W]));
endmodule

bind dual_irq_level_ctrl dilc_checker #(
    .SRC_W    (SRC_W),
    .RST_BIT  (RST_BIT),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .NCPU     (NCPU),
    .LVL_W    (LVL_W),
    .SEL_W    (SEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .trig_i    (trig_i),
    .mask_we_i (mask_we_i),
    .cmd_we_i  (cmd_we_i),
    .ack_i     (ack_i),
    .ack_sel_i (ack_sel_i),
    .ack_vec_o (ack_vec_o),
    .lvl_o     (lvl_o),
    .rec_o     (rec_o)
);

// File: tb/dual_irq_level_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_irq_level_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic [7:0] trig_i = '0;
    logic [1:0] mask_we_i = '0;
    logic [3:0] mask_wdata_i = '0;
    logic       cmd_we_i = 1'b0;
    logic [1:0] cmd_wdata_i = '0;
    logic [1:0] pint_set_i = '0;
    logic [3:0] pint_lvl_i = '0;
    logic [7:0] pint_vec_i = '0;
    logic       ack_i = 1'b0;
    logic [0:0] ack_sel_i = '0;
    logic [7:0] ack_vec_o;
    logic [7:0] lvl_o;
    logic [7:0] rec_o;

    always #2.5 clk = ~clk;

    dual_irq_level_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .trig_i(trig_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
        .pint_set_i(pint_set_i), .pint_lvl_i(pint_lvl_i), .pint_vec_i(pint_vec_i),
        .ack_i(ack_i), .ack_sel_i(ack_sel_i), .ack_vec_o(ack_vec_o),
        .lvl_o(lvl_o), .rec_o(rec_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference state, built from the requirements
    logic [3:0] mask_m [2];
    logic [7:0] pend_m [2];
    logic       shr_m;
    logic [1:0] cmd_m;
    logic [3:0] ilvl_m [2];
    logic [7:0] ivec_m [2];
    logic [3:0] rec_m  [2];

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_lvl(input int c);
        logic [7:0] u;
        u = pend_m[c];
        if (shr_m) u[7] = 1'b1;
        if (mask_m[c][1] && cmd_m[c]) u[4] = 1'b1;
        for (int i = 7; i >= 0; i--) if (u[i]) return 2 * i;
        return 0;
    endfunction

    function automatic int lvl_of(input int c);
        return int'(lvl_o[c*4 +: 4]);
    endfunction

    function automatic int rec_of(input int c);
        return int'(rec_o[c*4 +: 4]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_clr();
        for (int c = 0; c < 2; c++) begin
            mask_m[c] = '0; pend_m[c] = '0; ilvl_m[c] = '0; ivec_m[c] = '0; rec_m[c] = '0;
        end
        shr_m = 1'b0;
        cmd_m = '0;
    endtask

    task automatic do_clr();
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        model_clr();
    endtask

    task automatic wr_mask(input int c, input logic [3:0] v);
        mask_we_i[c] = 1'b1;
        mask_wdata_i = v;
        tick();
        mask_we_i = '0;
        mask_m[c] = v;
    endtask

    task automatic wr_cmd(input logic [1:0] v);
        cmd_we_i = 1'b1;
        cmd_wdata_i = v;
        tick();
        cmd_we_i = 1'b0;
        cmd_m = v;
    endtask

    task automatic chk_lvls(input string tag);
        chk(tag, lvl_of(0), exp_lvl(0));
        chk(tag, lvl_of(1), exp_lvl(1));
    endtask

    // R4: output must not move before the edge that registers the trigger
    task automatic pulse(input logic [7:0] t, input bit chk_early);
        int before0;
        before0 = exp_lvl(0);
        trig_i = t;
        #1;
        if (chk_early) chk("R4 early", lvl_of(0), before0);
        tick();
        trig_i = '0;
        if (t[7]) shr_m = 1'b1;
        for (int c = 0; c < 2; c++) begin
            logic [7:0] g;
            g = {1'b0, mask_m[c], 3'b000};
            g[4] = 1'b0;
            pend_m[c] = pend_m[c] | (t & g);
        end
    endtask

    task automatic set_pint(input int c, input logic [3:0] l, input logic [7:0] v);
        pint_set_i[c] = 1'b1;
        pint_lvl_i = l;
        pint_vec_i = v;
        tick();
        pint_set_i = '0;
        ilvl_m[c] = l;
        ivec_m[c] = v;
    endtask

    task automatic do_ack(input int c, input string tag);
        int ext;
        int ev;
        ext = exp_lvl(c);
        ack_i = 1'b1;
        ack_sel_i = 1'(c);
        #1;
        if (ext > int'(ilvl_m[c])) ev = 64 + ext / 2;
        else ev = int'(ivec_m[c]);
        chk(tag, int'(ack_vec_o), ev);
        tick();
        ack_i = 1'b0;
        if (!(ext > int'(ilvl_m[c]))) begin
            ilvl_m[c] = '0;
            rec_m[c] = 4'(ext);
        end
        chk(tag, rec_of(0), int'(rec_m[0]));
        chk(tag, rec_of(1), int'(rec_m[1]));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        model_clr();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 lvl", int'(lvl_o), 0);
        chk("R1 rec", int'(rec_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", int'(lvl_o), 0);

        // R2 R3 R5: every single trigger against every mask, per processor
        for (int c = 0; c < 2; c++) begin
            for (int m = 0; m < 16; m++) begin
                for (int b = 0; b < 8; b++) begin
                    do_clr();
                    wr_mask(c, 4'(m));
                    wr_mask(1 - c, 4'(~m));
                    pulse(8'(1 << b), (b == 0));
                    if (b == 7) chk_lvls("R3 reset request");
                    else if (b == 4 || b < 3) chk_lvls("R5 ignored bit");
                    else chk_lvls("R2 masked latch");
                end
            end
        end

        // R4: priority across accumulated sources
        do_clr();
        wr_mask(0, 4'hF);
        wr_mask(1, 4'h1);
        pulse(8'h08, 1'b1); chk_lvls("R4 pwm");
        pulse(8'h40, 1'b1); chk_lvls("R4 vblank over pwm");
        pulse(8'h20, 1'b1); chk_lvls("R4 lower does not lower");
        pulse(8'h80, 1'b1); chk_lvls("R4 reset on top");

        // R6: sticky after mask clear
        do_clr();
        wr_mask(0, 4'h8);
        pulse(8'h40, 1'b0);
        wr_mask(0, 4'h0);
        chk_lvls("R6 sticky");
        pulse(8'h08, 1'b0);
        chk("R6 blocked", lvl_of(0), 12);

        // R5: command AND of mask bit 1 and command bit
        for (int cv = 0; cv < 4; cv++) begin
            for (int mb = 0; mb < 4; mb++) begin
                do_clr();
                wr_mask(0, {2'b00, mb[0], 1'b0});
                wr_mask(1, {2'b00, mb[1], 1'b0});
                wr_cmd(2'(cv));
                chk_lvls("R5 command level");
                wr_cmd(2'b00);
                chk_lvls("R5 command drop");
            end
        end

        // R7 R8 R9 R11: acknowledge arbitration
        for (int il = 0; il < 16; il++) begin
            for (int e = 0; e < 4; e++) begin
                logic [7:0] tb;
                do_clr();
                wr_mask(0, 4'hF);
                tb = (e == 0) ? 8'h00 : (e == 1) ? 8'h08 : (e == 2) ? 8'h20 : 8'h80;
                if (tb != 0) pulse(tb, 1'b0);
                set_pint(0, 4'(il), 8'(8'h10 + il));
                set_pint(1, 4'(15 - il), 8'h3A);
                do_ack(0, "R7 R8 arbitration cpu0");
                do_ack(0, "R8 after retire");
                do_ack(1, "R11 R9 cpu1 separate");
            end
        end

        // R10: clear beats a same-cycle trigger and wipes masks
        do_clr();
        wr_mask(0, 4'hF);
        wr_cmd(2'b11);
        pulse(8'h40, 1'b0);
        clr_i = 1'b1;
        trig_i = 8'h80;
        tick();
        clr_i = 1'b0;
        trig_i = '0;
        model_clr();
        chk_lvls("R10 clear");
        pulse(8'h40, 1'b0);
        chk("R10 mask cleared", lvl_of(0), 0);

        summary();
        $finish;
    end
endmodule